// File: doc/BRIEF.md
# Phase-Gated Four-Input Lookup Gate

This block is one gate of a phased logic netlist, run from a clock. Every signal is a two-bit token: one bit holds the logic value and the other holds timing. The XOR of the two bits gives the token's phase, which is either even or odd. From one token to the next a signal flips exactly one of its two bits, so the phase always changes and the value may or may not change.

The gate keeps its own phase, even or odd. On a clock edge where all four input tokens carry the gate's phase, the gate fires. It looks up a 16-entry truth table with the four input value bits and registers the result as the new output value. It sets the output timing bit so that the output token carries the phase the gate had when it fired. The gate's phase then flips, so the same set of tokens cannot fire it a second time. While any input still carries the other phase the gate waits and its output holds.

The truth table is a configuration input. It is read only at the moment of firing.

Top module: `pl_lut4_gate`

## Requirements
- R1: A token is two bits, with bit 1 the timing bit and bit 0 the value bit. The phase of a token is timing XOR value, where 0 means even and 1 means odd. This gives the codes 00 = even-0, 11 = even-1, 10 = odd-0 and 01 = odd-1.
- R2: While reset is active and right after it ends, the gate phase is even and the output token is odd-0 (10).
- R3: The gate fires on a clock edge only when every input token's phase equals the gate phase. On any other edge the output token keeps its value.
- R4: After a firing, the output value bit equals `lut_cfg[idx]`. Here `idx` is built from the input value bits, with input 3 as the MSB and input 0 as the LSB.
- R5: After a firing, the output token's phase equals the gate phase from before that firing. Output phases therefore alternate even, odd, even and so on, starting from even.
- R6: Each firing changes exactly one of the two output bits.
- R7: Each firing flips the gate phase, so input tokens that stay unchanged cause no second firing.
- R8: A change of `lut_cfg` while the gate is not firing has no effect on the output token. The table value present at the firing edge is the one used.
- R9: When input tokens arrive on different cycles, the gate fires on the edge at which the last matching token is present, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_tok | input | 8 | Four input tokens; `in_tok[i]` is token i as {timing, value} |
| lut_cfg | input | 16 | Truth table, indexed by the input value bits |
| out_tok | output | 2 | Output token as {timing, value} |

## Verification
A token that completes a matching set is driven just after a falling edge. The gate fires at the following rising edge, and the new output token is sampled at the next falling edge, half a cycle after the register updates. After a partial arrival or a change of the truth table, the bench waits through one or more rising edges and then samples at a falling edge, confirming that the output token stayed the same. The expected output is worked out in the bench from the token encoding, the bench's own record of the gate phase, and the truth-table bit chosen by the driven values.

// File: rtl/pl_gate_pkg.sv
// Shared token type, phase type and encode/decode helpers for the phased gate.
// Assumes a token is {timing, value} and its phase is timing XOR value.
package pl_gate_pkg;

    typedef logic [1:0] pl_tok_t;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } pl_phase_e;

    // Phase carried by a token.
    function automatic pl_phase_e tok_phase(input pl_tok_t tok);
        return pl_phase_e'(tok[1] ^ tok[0]);
    endfunction

    // Build a token with the given value and phase.
    function automatic pl_tok_t tok_make(input logic val, input pl_phase_e ph);
        return {val ^ ph, val};
    endfunction

    // Opposite phase.
    function automatic pl_phase_e phase_flip(input pl_phase_e ph);
        return (ph == PH_EVEN) ? PH_ODD : PH_EVEN;
    endfunction

endpackage

// File: rtl/pl_phase_match.sv
// Completion detector: compares every input token's phase with the gate phase
// and separates out the value bits. Purely combinational. Assumes each input
// token is a legal two-bit code.
module pl_phase_match
    import pl_gate_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  logic [NUM_IN-1:0][1:0] in_tok,
    input  pl_phase_e              gate_phase,
    output logic                   all_match,
    output logic [NUM_IN-1:0]      in_val
);

    logic [NUM_IN-1:0] match_vec;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
        // One lane: phase equality and value extraction.
        assign match_vec[i] = (tok_phase(in_tok[i]) == gate_phase);
        assign in_val[i]    = in_tok[i][0];
    end

    // Fire enable when every lane matches.
    assign all_match = &match_vec;

endmodule

// File: rtl/pl_lut_eval.sv
// Truth-table evaluator built as a binary mux tree, one level per select bit.
// Select bit 0 resolves the first level. Assumes LUT_W equals 2**NUM_IN.
module pl_lut_eval #(
    parameter int NUM_IN = 4,
    parameter int LUT_W  = 1 << NUM_IN
) (
    input  logic [LUT_W-1:0]  cfg,
    input  logic [NUM_IN-1:0] sel,
    output logic              lut_out
);

    for (genvar l = 0; l < NUM_IN; l++) begin : g_lvl
        localparam int W = LUT_W >> (l + 1);
        logic [2*W-1:0] prev;
        logic [W-1:0]   nodes;
        if (l == 0) begin : g_first
            // Tree leaves come straight from the table.
            assign prev = cfg;
        end else begin : g_rest
            // Inner level takes the previous level's outputs.
            assign prev = g_lvl[l-1].nodes;
        end
        for (genvar j = 0; j < W; j++) begin : g_mux
            // 2:1 mux steered by select bit l.
            assign nodes[j] = sel[l] ? prev[2*j+1] : prev[2*j];
        end
    end

    assign lut_out = g_lvl[NUM_IN-1].nodes[0];

endmodule

// File: rtl/pl_out_stage.sv
// State of the gate: the phase register and the output token register.
// On fire it captures the new value, encodes it with the current phase and
// flips the phase. Assumes fire is asserted only when inputs match.
module pl_out_stage
    import pl_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fire,
    input  logic      new_val,
    output pl_phase_e gate_phase,
    output pl_tok_t   out_tok
);

    pl_phase_e gate_q;
    pl_tok_t   out_q;

    // Phase and output token update, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= PH_EVEN;
            out_q  <= tok_make(1'b0, PH_ODD);
        end else if (fire) begin
            out_q  <= tok_make(new_val, gate_q);
            gate_q <= phase_flip(gate_q);
        end
    end

    assign gate_phase = gate_q;
    assign out_tok    = out_q;

    AST_HOLD_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(out_tok)); // R3

    AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> $countones(out_tok ^ $past(out_tok)) == 1); // R6

    AST_OUT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (out_tok[1] ^ out_tok[0]) == $past(gate_phase)); // R5

    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> gate_phase != $past(gate_phase)); // R7

    AST_RESET_TOKEN: assert property (@(posedge clk)
        !rst_n |=> (out_tok == 2'b10) && (gate_phase == PH_EVEN)); // R2

endmodule

// File: rtl/pl_lut4_gate.sv
// Phased logic gate with a four-input truth table. It fires when all input
// token phases equal its own phase, drives an output token of that phase and
// flips phase. Assumes every input changes exactly one bit per token.
module pl_lut4_gate
    import pl_gate_pkg::*;
#(
    parameter int NUM_IN = 4,
    localparam int LUT_W = 1 << NUM_IN
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_IN-1:0][1:0] in_tok,
    input  logic [LUT_W-1:0]       lut_cfg,
    output logic [1:0]             out_tok
);

    pl_phase_e         gate_phase;
    logic              fire;
    logic [NUM_IN-1:0] in_val;
    logic              lut_bit;

    pl_phase_match #(.NUM_IN(NUM_IN)) i_match (
        .in_tok     (in_tok),
        .gate_phase (gate_phase),
        .all_match  (fire),
        .in_val     (in_val)
    );

    pl_lut_eval #(.NUM_IN(NUM_IN), .LUT_W(LUT_W)) i_lut (
        .cfg     (lut_cfg),
        .sel     (in_val),
        .lut_out (lut_bit)
    );

    pl_out_stage i_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .new_val    (lut_bit),
        .gate_phase (gate_phase),
        .out_tok    (out_tok)
    );

    AST_LUT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_tok[0] == $past(lut_cfg[in_val])); // R4

endmodule

// File: tb/test_pl_lut4_gate.sv
`timescale 1ns/1ps
module test_pl_lut4_gate;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [3:0][1:0] in_tok;
    logic [15:0]     lut_cfg;
    logic [1:0]      out_tok;

    int         n_chk  = 0;
    int         n_fail = 0;
    logic       gp;          // expected gate phase, 0 = even
    logic [3:0] cur_v;       // value bits currently driven
    logic [1:0] prev_out;

    always #2.5 clk = ~clk;

    pl_lut4_gate i_pl_lut4_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_tok  (in_tok),
        .lut_cfg (lut_cfg),
        .out_tok (out_tok)
    );

    function automatic logic [1:0] enc(input logic v, input logic ph);
        return {v ^ ph, v};
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: out_tok=%b expected %b", req, act, exp);
        end
    endtask

    // Move one input to the current gate phase with value v.
    task automatic put_in(input int i, input logic v);
        in_tok[i] = enc(v, gp);
        cur_v[i]  = v;
    endtask

    // Present a full token set, then check output value, phase and one-bit step.
    task automatic wave(input logic [3:0] vals, input string req);
        logic       lv;
        logic [1:0] exp;
        @(negedge clk);
        prev_out = out_tok;
        for (int i = 0; i < 4; i++) put_in(i, vals[i]);
        @(negedge clk);
        lv  = lut_cfg[vals];
        exp = enc(lv, gp);
        chk(req, out_tok, exp);
        n_chk++;
        if ($countones(out_tok ^ prev_out) != 1) begin
            n_fail++;
            $display("FAIL R6: step %b -> %b expected one bit", prev_out, out_tok);
        end
        gp = ~gp;
    endtask

    task automatic t_reset;
        rst_n   = 1'b0;
        lut_cfg = 16'h0000;
        for (int i = 0; i < 4; i++) in_tok[i] = 2'b10; // odd-0
        cur_v = 4'b0000;
        gp    = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 in reset", out_tok, 2'b10);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 after reset", out_tok, 2'b10);
        chk("R3 odd inputs vs even gate", out_tok, 2'b10);
    endtask

    task automatic t_patterns;
        lut_cfg = 16'h6996; // parity
        wave(4'b0001, "R4 parity 0001");
        wave(4'b0111, "R4 parity 0111");
        wave(4'b1111, "R5 parity 1111");
        lut_cfg = 16'h8000; // AND
        wave(4'b1111, "R4 and 1111");
        wave(4'b1110, "R4 and 1110");
        lut_cfg = 16'h0400; // only index 10
        wave(4'b1010, "R4 index 10");
        // R1: gate was odd for this firing, value 1 -> odd-1 code 01
        chk("R1 odd-1 code", out_tok, 2'b01);
        wave(4'b0101, "R4 index 5");
        // R1: even firing, value 0 -> even-0 code 00
        chk("R1 even-0 code", out_tok, 2'b00);
    endtask

    task automatic t_no_refire;
        logic [1:0] held;
        held = out_tok;
        repeat (3) @(negedge clk);
        chk("R7 no second firing", out_tok, held);
    endtask

    task automatic t_partial;
        logic [1:0] held;
        logic       lv;
        lut_cfg = 16'hFFFE; // OR
        held = out_tok;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            put_in(i, 1'b0);
            @(negedge clk);
            chk("R9 partial arrival holds", out_tok, held);
        end
        @(negedge clk);
        put_in(3, 1'b0);
        @(negedge clk);
        lv = lut_cfg[cur_v];
        chk("R9 fires on last arrival", out_tok, enc(lv, gp));
        gp = ~gp;
    endtask

    task automatic t_cfg_ignored;
        logic [1:0] held;
        lut_cfg = 16'h0000;
        held = out_tok;
        @(negedge clk);
        put_in(0, 1'b1);
        put_in(1, 1'b1);
        @(negedge clk);
        lut_cfg = 16'hFFFF;
        @(negedge clk);
        chk("R8 table change without firing", out_tok, held);
        lut_cfg = 16'h0000;
        @(negedge clk);
        lut_cfg = 16'h0008; // index 3 only
        put_in(2, 1'b0);
        put_in(3, 1'b0);
        @(negedge clk);
        chk("R8 table at firing edge", out_tok, enc(1'b1, gp));
        gp = ~gp;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        t_reset();
        t_patterns();
        t_no_refire();
        t_partial();
        t_cfg_ignored();
        t_no_refire();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule